// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the bookkeeping for one circular ring of DMA descriptors held in memory. It stores the ring's base address, its size, a producer (write) index and a consumer (read) index. One of the two indices belongs to software and the other to a hardware engine. The parameter `SW_PRODUCER` decides which is which. When it is 1, software fills the ring and the engine drains it, as for a receive free queue or a transmit submit queue. When it is 0, the engine fills the ring and software drains it, as for a receive completion or transmit return queue.

Software reaches the block through a single-cycle register write port. Pointers travel as byte offsets of 32-byte slots, and the ring size is written as the slot count multiplied by eight. The base address, the ring size and the engine-owned index can only be rewritten while the matching bit is set in a separate unlock register. The engine side is modelled by one advance strobe. The block reports the number of occupied slots, empty, full, near-empty and near-full flags against programmable thresholds, and the memory address of the slot the engine will touch next.

Top module: `desc_ring_top`

## Requirements
- R1: After reset both offsets read 0 and the fill count is 0. The empty and near-empty flags are set, full and near-full are clear, and the descriptor address is 0. The ring holds `MAX_DEPTH` slots, the near-empty threshold is 0 and the near-full threshold is `MAX_DEPTH`-1.
- R2: Register select codes are: 0 unlock, 1 base address, 2 ring size, 3 software-owned pointer, 4 engine-owned pointer, 5 near-empty threshold, 6 near-full threshold, 7 no register. In the unlock register, bit 2 opens the base address, bit 1 opens the ring size and bit 0 opens the engine-owned pointer. A write to any of these three while its bit is clear leaves it unchanged.
- R3: Pointer writes carry a byte offset. The slot index is bits [IDX_W+4:5] of the value, reduced modulo the ring size. The offset outputs show the index multiplied by 32.
- R4: A ring-size write carries the slot count shifted left by 3. It is accepted only when the count is a power of two from 2 to `MAX_DEPTH`, and an accepted write clears both indices to 0. Any other value is ignored.
- R5: The fill count is (write index - read index) modulo the ring size. Empty means a fill of 0, and full means a fill of ring size - 1, so the two offsets differ whenever the ring is full.
- R6: Near-empty is set when fill <= the near-empty threshold. Near-full is set when fill >= the near-full threshold. Thresholds take bits [IDX_W-1:0] of the write and need no unlock.
- R7: With `SW_PRODUCER`=1, an advance strobe moves the read index forward by one, wrapping at the ring size. The strobe is ignored while the ring is empty.
- R8: With `SW_PRODUCER`=0, an advance strobe moves the write index forward by one. The strobe is ignored while the ring is full, and software owns the read index.
- R9: The descriptor address equals base + 32 x (engine-owned index). Like every other output, it shows the effect of a stimulus after the next rising clock edge.
- R10: A software-pointer write is always accepted, including in the same cycle as an advance. An unlocked engine-pointer write takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code (R2) |
| regWdata | input | 32 | Register write data |
| engAdv | input | 1 | Engine advance strobe |
| prodOff | output | IDX_W+5 | Write index as a byte offset |
| consOff | output | IDX_W+5 | Read index as a byte offset |
| fillCount | output | IDX_W | Occupied slots |
| isEmpty | output | 1 | Ring empty |
| isFull | output | 1 | Ring full |
| nearEmpty | output | 1 | Fill at or below near-empty threshold |
| nearFull | output | 1 | Fill at or above near-full threshold |
| descAddr | output | ADDR_W | Memory address of the engine's next slot |

## Verification
Every result is due one rising edge after its stimulus. This covers register writes, unlock changes, ring-size loads and advance strobes. All outputs are combinational views of registered state, so no output has a second stage of latency. The driver applies each stimulus on a falling edge and pushes the model's expected outputs for the following edge. The monitor then pops and compares them 5 ns after that rising edge, so each expectation is checked in exactly the cycle the design should show it.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  // Each descriptor slot occupies 32 bytes; ring size is written as count << 3
  localparam int DESC_SHIFT  = 5;
  localparam int DEPTH_SHIFT = 3;

  // Unlock register bit positions (decoded by the control module)
  localparam int UNLOCK_HWPTR_BIT = 0;
  localparam int UNLOCK_DEPTH_BIT = 1;
  localparam int UNLOCK_BASE_BIT  = 2;

  typedef enum logic [2:0] {
    RS_UNLOCK = 3'd0,
    RS_BASE   = 3'd1,
    RS_DEPTH  = 3'd2,
    RS_SWPTR  = 3'd3,
    RS_HWPTR  = 3'd4,
    RS_AETH   = 3'd5,
    RS_AFTH   = 3'd6,
    RS_NONE   = 3'd7
  } reg_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldBase;
    logic ldDepth;
    logic ldSwPtr;
    logic ldHwPtr;
    logic ldAeTh;
    logic ldAfTh;
    logic advHw;
  } ring_strobe_t;

endpackage

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int MAX_DEPTH   = 1024,
  parameter bit SW_PRODUCER = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  reg_sel_e                     regSel,
  input  logic [31:0]                  regWdata,
  input  logic                         engAdv,
  input  logic                         ringEmpty,
  input  logic                         ringFull,
  output ring_strobe_t                 stb,
  output logic [$clog2(MAX_DEPTH)-1:0] depthMaskNew,
  output logic [2:0]                   unlockBits
);

  localparam int IDX_W = $clog2(MAX_DEPTH);
  localparam int CNT_W = 32 - DEPTH_SHIFT;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_DEPTH);

  logic [2:0]       unlockQ;
  logic [CNT_W-1:0] cntReq;
  logic             cntPow2;
  logic             depthOk;
  logic             engOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlockQ <= '0;
    end else if (regWr && regSel == RS_UNLOCK) begin
      unlockQ <= regWdata[2:0];
    end
  end

  assign unlockBits = unlockQ;

  // Ring-size validation: power of two between 2 and MAX_DEPTH
  assign cntReq       = regWdata[31:DEPTH_SHIFT];
  assign cntPow2      = (cntReq & (cntReq - 1'b1)) == '0;
  assign depthOk      = cntPow2 && (cntReq >= CNT_W'(2)) && (cntReq <= MAX_CNT);
  assign depthMaskNew = cntReq[IDX_W-1:0] - 1'b1;

  // Which condition blocks the engine depends on the ring's direction
  generate
    if (SW_PRODUCER) begin : g_eng_consumes
      assign engOk = !ringEmpty;
    end else begin : g_eng_produces
      assign engOk = !ringFull;
    end
  endgenerate

  always_comb begin
    stb = '0;
    if (regWr) begin
      unique case (regSel)
        RS_BASE:  stb.ldBase  = unlockQ[UNLOCK_BASE_BIT];
        RS_DEPTH: stb.ldDepth = unlockQ[UNLOCK_DEPTH_BIT] && depthOk;
        RS_SWPTR: stb.ldSwPtr = 1'b1;
        RS_HWPTR: stb.ldHwPtr = unlockQ[UNLOCK_HWPTR_BIT];
        RS_AETH:  stb.ldAeTh  = 1'b1;
        RS_AFTH:  stb.ldAfTh  = 1'b1;
        default:  ;
      endcase
    end
    stb.advHw = engAdv && engOk && !stb.ldHwPtr && !stb.ldDepth;
  end

endmodule

// File: rtl/desc_ring_dp.sv
module desc_ring_dp
  import desc_ring_pkg::*;
#(
  parameter int MAX_DEPTH   = 1024,
  parameter int ADDR_W      = 32,
  parameter bit SW_PRODUCER = 1'b1
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  ring_strobe_t                            stb,
  input  logic [31:0]                             regWdata,
  input  logic [$clog2(MAX_DEPTH)-1:0]            depthMaskNew,
  output logic [$clog2(MAX_DEPTH)+DESC_SHIFT-1:0] prodOff,
  output logic [$clog2(MAX_DEPTH)+DESC_SHIFT-1:0] consOff,
  output logic [$clog2(MAX_DEPTH)-1:0]            fillCount,
  output logic                                    isEmpty,
  output logic                                    isFull,
  output logic                                    nearEmpty,
  output logic                                    nearFull,
  output logic [ADDR_W-1:0]                       descAddr
);

  localparam int IDX_W = $clog2(MAX_DEPTH);
  localparam int OFF_W = IDX_W + DESC_SHIFT;
  localparam logic [IDX_W-1:0] RST_MASK = IDX_W'(MAX_DEPTH - 1);

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  maskQ;
  logic [IDX_W-1:0]  wrIdxQ;
  logic [IDX_W-1:0]  rdIdxQ;
  logic [IDX_W-1:0]  aeThQ;
  logic [IDX_W-1:0]  afThQ;
  logic [IDX_W-1:0]  ptrIdx;
  logic [IDX_W-1:0]  hwIdx;

  assign ptrIdx = regWdata[DESC_SHIFT +: IDX_W] & maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      maskQ <= RST_MASK;
      aeThQ <= '0;
      afThQ <= RST_MASK;
    end else begin
      if (stb.ldBase)  baseQ <= regWdata[ADDR_W-1:0];
      if (stb.ldDepth) maskQ <= depthMaskNew;
      if (stb.ldAeTh)  aeThQ <= regWdata[IDX_W-1:0];
      if (stb.ldAfTh)  afThQ <= regWdata[IDX_W-1:0];
    end
  end

  // Ownership of the two indices follows the ring direction
  generate
    if (SW_PRODUCER) begin : g_sw_owns_wr
      always_ff @(posedge clk) begin
        if (!rstN || stb.ldDepth) begin
          wrIdxQ <= '0;
          rdIdxQ <= '0;
        end else begin
          if (stb.ldSwPtr) wrIdxQ <= ptrIdx;
          if (stb.ldHwPtr)     rdIdxQ <= ptrIdx;
          else if (stb.advHw)  rdIdxQ <= (rdIdxQ + 1'b1) & maskQ;
        end
      end
      assign hwIdx = rdIdxQ;
    end else begin : g_sw_owns_rd
      always_ff @(posedge clk) begin
        if (!rstN || stb.ldDepth) begin
          wrIdxQ <= '0;
          rdIdxQ <= '0;
        end else begin
          if (stb.ldSwPtr) rdIdxQ <= ptrIdx;
          if (stb.ldHwPtr)     wrIdxQ <= ptrIdx;
          else if (stb.advHw)  wrIdxQ <= (wrIdxQ + 1'b1) & maskQ;
        end
      end
      assign hwIdx = wrIdxQ;
    end
  endgenerate

  assign fillCount = (wrIdxQ - rdIdxQ) & maskQ;
  assign isEmpty   = fillCount == '0;
  assign isFull    = fillCount == maskQ;
  assign nearEmpty = fillCount <= aeThQ;
  assign nearFull  = fillCount >= afThQ;

  assign prodOff  = {wrIdxQ, {DESC_SHIFT{1'b0}}};
  assign consOff  = {rdIdxQ, {DESC_SHIFT{1'b0}}};
  assign descAddr = baseQ + ADDR_W'({hwIdx, {DESC_SHIFT{1'b0}}});

endmodule

// File: rtl/desc_ring_top.sv
module desc_ring_top
  import desc_ring_pkg::*;
#(
  parameter int MAX_DEPTH   = 1024,
  parameter int ADDR_W      = 32,
  parameter bit SW_PRODUCER = 1'b1
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    regWr,
  input  logic [2:0]                              regSel,
  input  logic [31:0]                             regWdata,
  input  logic                                    engAdv,
  output logic [$clog2(MAX_DEPTH)+DESC_SHIFT-1:0] prodOff,
  output logic [$clog2(MAX_DEPTH)+DESC_SHIFT-1:0] consOff,
  output logic [$clog2(MAX_DEPTH)-1:0]            fillCount,
  output logic                                    isEmpty,
  output logic                                    isFull,
  output logic                                    nearEmpty,
  output logic                                    nearFull,
  output logic [ADDR_W-1:0]                       descAddr
);

  localparam int IDX_W = $clog2(MAX_DEPTH);

  ring_strobe_t     stb;
  logic [IDX_W-1:0] depthMaskNew;
  logic [2:0]       unlockBits;

  desc_ring_ctrl #(
    .MAX_DEPTH  (MAX_DEPTH),
    .SW_PRODUCER(SW_PRODUCER)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regSel      (reg_sel_e'(regSel)),
    .regWdata    (regWdata),
    .engAdv      (engAdv),
    .ringEmpty   (isEmpty),
    .ringFull    (isFull),
    .stb         (stb),
    .depthMaskNew(depthMaskNew),
    .unlockBits  (unlockBits)
  );

  desc_ring_dp #(
    .MAX_DEPTH  (MAX_DEPTH),
    .ADDR_W     (ADDR_W),
    .SW_PRODUCER(SW_PRODUCER)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .regWdata    (regWdata),
    .depthMaskNew(depthMaskNew),
    .prodOff     (prodOff),
    .consOff     (consOff),
    .fillCount   (fillCount),
    .isEmpty     (isEmpty),
    .isFull      (isFull),
    .nearEmpty   (nearEmpty),
    .nearFull    (nearFull),
    .descAddr    (descAddr)
  );

endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int IDX_W       = 10,
  parameter int ADDR_W      = 32,
  parameter bit SW_PRODUCER = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [2:0]        regSel,
  input logic              engAdv,
  input logic [2:0]        unlockBits,
  input logic              depthLoad,
  input logic [IDX_W+4:0]  prodOff,
  input logic [IDX_W+4:0]  consOff,
  input logic [IDX_W-1:0]  fillCount,
  input logic              isEmpty,
  input logic              isFull,
  input logic [ADDR_W-1:0] descAddr
);

  // R5: a full ring never shows equal offsets
  assert_full_ptr_differ_R5: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> prodOff != consOff);

  // R2: a locked base write cannot move the descriptor address
  assert_locked_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 3'd1 && !unlockBits[2] && !engAdv) |=> $stable(descAddr));

  // R4: an accepted ring-size load clears both offsets
  assert_depth_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    depthLoad |=> (prodOff == '0 && consOff == '0));

  generate
    if (SW_PRODUCER) begin : g_cons
      // R7: advance on an empty ring is ignored
      assert_empty_adv_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
        (isEmpty && engAdv && !regWr) |=> $stable(consOff));
      // R7: an accepted advance removes exactly one slot
      assert_adv_step_R7: assert property (@(posedge clk) disable iff (!rstN)
        (engAdv && !isEmpty && !regWr) |=> fillCount == ($past(fillCount) - 1'b1));
    end else begin : g_prod
      // R8: advance on a full ring is ignored
      assert_full_adv_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
        (isFull && engAdv && !regWr) |=> $stable(prodOff));
    end
  endgenerate

endmodule

bind desc_ring_top desc_ring_chk #(
  .IDX_W      (IDX_W),
  .ADDR_W     (ADDR_W),
  .SW_PRODUCER(SW_PRODUCER)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWr     (regWr),
  .regSel    (regSel),
  .engAdv    (engAdv),
  .unlockBits(unlockBits),
  .depthLoad (stb.ldDepth),
  .prodOff   (prodOff),
  .consOff   (consOff),
  .fillCount (fillCount),
  .isEmpty   (isEmpty),
  .isFull    (isFull),
  .descAddr  (descAddr)
);

// File: tb/desc_ring_top_bench.sv
`timescale 1ns/1ps
module desc_ring_top_bench;

  localparam int IDX_W  = 10;
  localparam int OFF_W  = IDX_W + 5;
  localparam int MAXD   = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regSel = 3'd7;
  logic [31:0] regWdata = '0;
  logic engAdv = 1'b0;

  always #10 clk = ~clk;

  logic [OFF_W-1:0] prodOff, consOff, hpProd, hpCons;
  logic [IDX_W-1:0] fillCount, hpFill;
  logic isEmpty, isFull, nearEmpty, nearFull;
  logic hpEmpty, hpFull, hpNe, hpNf;
  logic [31:0] descAddr, hpAddr;

  desc_ring_top u_desc_ring_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .engAdv(engAdv), .prodOff(prodOff), .consOff(consOff), .fillCount(fillCount),
    .isEmpty(isEmpty), .isFull(isFull), .nearEmpty(nearEmpty), .nearFull(nearFull),
    .descAddr(descAddr)
  );

  desc_ring_top #(.SW_PRODUCER(1'b0)) u_desc_ring_top_hp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .engAdv(engAdv), .prodOff(hpProd), .consOff(hpCons), .fillCount(hpFill),
    .isEmpty(hpEmpty), .isFull(hpFull), .nearEmpty(hpNe), .nearFull(hpNf),
    .descAddr(hpAddr)
  );

  typedef struct {
    string            tag;
    logic [OFF_W-1:0] prod;
    logic [OFF_W-1:0] cons;
    logic [IDX_W-1:0] fill;
    logic [3:0]       flags;
    logic [31:0]      addr;
  } exp_t;

  exp_t expQ[$];
  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // Reference state of the default (software-producer) instance
  logic [31:0]      mBase = '0;
  logic [IDX_W-1:0] mMask = IDX_W'(MAXD - 1);
  logic [IDX_W-1:0] mWr = '0, mRd = '0, mAe = '0, mAf = IDX_W'(MAXD - 1);
  logic [2:0]       mUnl = '0;

  task automatic step(input logic wr, input logic [2:0] sel, input logic [31:0] data,
                      input logic adv, input string tag);
    logic [IDX_W-1:0] occ;
    logic             hwWrite;
    logic [28:0]      cnt;
    exp_t             e;
    @(negedge clk);
    regWr = wr; regSel = sel; regWdata = data; engAdv = adv;
    occ = (mWr - mRd) & mMask;
    hwWrite = wr && sel == 3'd4 && mUnl[0];
    if (adv && occ != '0 && !hwWrite) mRd = (mRd + 1'b1) & mMask;
    if (wr) begin
      case (sel)
        3'd0: mUnl = data[2:0];
        3'd1: if (mUnl[2]) mBase = data;
        3'd2: begin
          cnt = data[31:3];
          if (mUnl[1] && cnt >= 2 && cnt <= 29'(MAXD) && (cnt & (cnt - 1)) == 0) begin
            mMask = IDX_W'(cnt - 1);
            mWr = '0;
            mRd = '0;
          end
        end
        3'd3: mWr = data[5 +: IDX_W] & mMask;
        3'd4: if (mUnl[0]) mRd = data[5 +: IDX_W] & mMask;
        3'd5: mAe = data[IDX_W-1:0];
        3'd6: mAf = data[IDX_W-1:0];
        default: ;
      endcase
    end
    occ     = (mWr - mRd) & mMask;
    e.tag   = tag;
    e.prod  = {mWr, 5'b0};
    e.cons  = {mRd, 5'b0};
    e.fill  = occ;
    e.flags = {occ == '0, occ == mMask, occ <= mAe, occ >= mAf};
    e.addr  = mBase + {17'b0, mRd, 5'b0};
    expQ.push_back(e);
  endtask

  // Monitor: compares 5 ns after the edge that should show each result
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checkCnt++;
        if (prodOff !== e.prod || consOff !== e.cons || fillCount !== e.fill ||
            {isEmpty, isFull, nearEmpty, nearFull} !== e.flags || descAddr !== e.addr) begin
          failCnt++;
          $display("FAIL %s: prod %0h/%0h cons %0h/%0h fill %0d/%0d flags %b/%b addr %h/%h",
                   e.tag, prodOff, e.prod, consOff, e.cons, fillCount, e.fill,
                   {isEmpty, isFull, nearEmpty, nearFull}, e.flags, descAddr, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 3'd7, 0, 0, "R1 reset state");
    // R7 / R8: empty ring ignores advance on consumer side, producer side advances
    for (int i = 0; i < 3; i++) step(0, 3'd7, 0, 1, "R7 advance on empty ring ignored");
    @(posedge clk);
    #5;
    checkCnt++;
    if (hpProd !== 15'd96 || hpFill !== 10'd3 || hpAddr !== 32'd96) begin
      failCnt++;
      $display("FAIL R8 engine producer: prod %0h/60 fill %0d/3 addr %h/60", hpProd, hpFill, hpAddr);
    end

    step(1, 3'd1, 32'h1000_0000, 0, "R2 locked base write ignored");
    step(1, 3'd0, 32'd4, 0, "R2 unlock base");
    step(1, 3'd1, 32'h8000_0000, 0, "R9 base loaded into address");
    step(1, 3'd0, 32'd0, 0, "R2 relock");
    step(1, 3'd3, 1023 * 32, 0, "R5 full at 1023 of 1024");
    step(1, 3'd2, 8 << 3, 0, "R2 locked ring size ignored");
    step(1, 3'd0, 32'd2, 0, "R2 unlock ring size");
    step(1, 3'd2, 8 << 3, 0, "R4 ring size 8 clears pointers");
    step(1, 3'd3, 3 * 32, 0, "R3 software pointer byte offset");
    step(1, 3'd2, 6 << 3, 0, "R4 non power of two ignored");
    step(1, 3'd2, 1 << 3, 0, "R4 count of one ignored");
    step(1, 3'd2, 2048 << 3, 0, "R4 count above maximum ignored");
    step(1, 3'd0, 32'd0, 0, "R2 relock");
    step(1, 3'd3, 7 * 32, 0, "R5 full with one slot left");
    step(1, 3'd3, 9 * 32, 0, "R3 pointer wraps modulo ring size");
    step(1, 3'd5, 32'd2, 0, "R6 near-empty threshold");
    step(1, 3'd6, 32'd5, 0, "R6 near-full threshold");
    step(1, 3'd3, 6 * 32, 0, "R6 fill six");
    for (int i = 0; i < 7; i++) step(0, 3'd7, 0, 1, "R7 consume and R6 flags");
    step(1, 3'd3, 2 * 32, 1, "R10 software write with advance");
    step(0, 3'd7, 0, 1, "R9 address follows engine index");
    step(0, 3'd7, 0, 1, "R7 read index wraps");
    step(1, 3'd4, 5 * 32, 0, "R2 locked engine pointer ignored");
    step(1, 3'd0, 32'd1, 0, "R2 unlock engine pointer");
    step(1, 3'd4, 1 * 32, 1, "R10 engine pointer write beats advance");
    step(1, 3'd0, 32'd0, 0, "R2 relock");
    step(1, 3'd4, 0, 0, "R2 relocked engine pointer ignored");
    step(0, 3'd7, 0, 0, "R9 idle hold");
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule